// File: doc/BRIEF.md
# Register-Mapped 32-Pin GPIO Port

This block is a general-purpose I/O port of 32 pins that sits behind a plain register bus. The bus has a read strobe, a write strobe, a word address, write data and combinational read data. Software drives the pins through an output latch and a direction register. Each of those two registers has set-alias and clear-alias addresses, so single pins can change without a read-modify-write. Every pin also has its own configuration word. That word holds the pin direction, an input-buffer disconnect bit, a pull select and a drive field. The direction bit in the configuration word is the same storage as the matching bit of the port-wide direction register.

The input register is rebuilt on every clock from the pin state. It resolves, in order: input buffer disconnect, output loopback, external drive, pull resistor, and holding of the last level when the pad floats. Outside the chip, each pad is given as a level plus a "driven" qualifier, so a released pad can be modelled. If a pin drives one level while the outside drives the other, a sticky conflict flag is raised. Software clears it through a status register.

Top module: `gpio_pad_port`

## Requirements
- R1: After reset, word addresses 0..7 (output, output-set, output-clear, input, direction, direction-set, direction-clear, status) all read 0, every configuration word (word address 64+pin) reads 0x2, and padOe and padOut are all 0.
- R2: A write to address 0 replaces the output latch. A write to address 1 sets the latch bits where the data bit is 1. A write to address 2 clears the latch bits where the data bit is 1. Zero data bits leave their pins unchanged. Reads of addresses 0, 1 and 2 all return the latch.
- R3: A write to address 4 replaces the direction register. A write to address 5 sets the direction bits where the data bit is 1. A write to address 6 clears the direction bits where the data bit is 1. Zero data bits leave their pins unchanged. Reads of addresses 4, 5 and 6 all return the direction register.
- R4: Bit 0 of configuration word n always equals direction bit n, whichever address last changed it. A configuration write sets direction bit n from data bit 0.
- R5: When configuration bit 1 is 0 (input buffer connected) and bit 0 is 0 (input), a pin whose pad is externally driven shows the pad level in the input register (address 3) one clock after the level is applied.
- R6: A connected input pin whose pad is released, and whose pull field (configuration bits 3:2) is 00 or 10, keeps the last level the input register held.
- R7: A connected input pin whose pad is released reads 1 when the pull field is 11 (pull-up) and 0 when it is 01 (pull-down).
- R8: A pin whose configuration bit 1 is 1 (input disconnected) reads 0 in the input register, whatever its pad or output does.
- R9: A connected pin configured as an output (bit 0 = 1) reads its own output latch bit in the input register, even if the pad is driven externally.
- R10: padOe equals the direction register and padOut equals the output latch, one clock after the write that changes them.
- R11: When an output pin's latch bit differs from the level of an externally driven pad, the conflict flag (status bit 0, port conflict) is set at the next clock. It stays set after the cause goes away, until a write with data bit 0 = 1 to address 7. If a clash and a clear happen in the same cycle, the clash wins.
- R12: A configuration word keeps bits 0..3 and the drive field in bits 10:8. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busRead | input | 1 | Read strobe; busRdata is 0 when low |
| busWrite | input | 1 | Write strobe, acted on at the clock edge |
| busAddr | input | 7 | Word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| padIn | input | 32 | Level of each pad as seen from outside |
| padDriven | input | 32 | 1 where an external source drives the pad |
| padOut | output | 32 | Output latch toward the pads |
| padOe | output | 32 | Output enable per pad (direction register) |
| conflict | output | 1 | Sticky drive-conflict flag |

## Verification
The hardest state to reach is the hold of a floating input. That value depends on the whole history of the pin: earlier pad levels, pull changes, loopback, and the cycle on which each of them took effect. The bench runs a per-pin model that advances exactly once per clock edge, using the pre-edge configuration. Directed steps then drive a pad, release it, and swap the pull and direction. A seeded random phase mixes pad releases with writes to every alias and configuration word, so held levels from loopback and pulls are also checked. The conflict clear is tried both with and without a clash in the same cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  // Word offsets of the port registers
  localparam int OFF_OUT    = 0;
  localparam int OFF_OUTSET = 1;
  localparam int OFF_OUTCLR = 2;
  localparam int OFF_IN     = 3;
  localparam int OFF_DIR    = 4;
  localparam int OFF_DIRSET = 5;
  localparam int OFF_DIRCLR = 6;
  localparam int OFF_STAT   = 7;
  localparam int OFF_CFG    = 64;

  // Configuration word fields
  localparam int CFG_DIR_BIT  = 0;
  localparam int CFG_DISC_BIT = 1;
  localparam int CFG_PULL_LO  = 2;
  localparam int CFG_DRV_LO   = 8;

  localparam logic [1:0] PULL_DOWN = 2'b01;
  localparam logic [1:0] PULL_UP   = 2'b11;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OUT, SEL_IN, SEL_DIR, SEL_STAT, SEL_CFG
  } rd_sel_e;

  typedef struct packed {
    logic    outWr;
    logic    outSet;
    logic    outClr;
    logic    dirWr;
    logic    dirSet;
    logic    dirClr;
    logic    statClr;
    logic    cfgWr;
    rd_sel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int NPINS  = 32,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           strobe,
  output logic [IDX_W-1:0]  cfgIdx
);

  localparam logic [ADDR_W-1:0] A_OUT  = ADDR_W'(OFF_OUT);
  localparam logic [ADDR_W-1:0] A_OSET = ADDR_W'(OFF_OUTSET);
  localparam logic [ADDR_W-1:0] A_OCLR = ADDR_W'(OFF_OUTCLR);
  localparam logic [ADDR_W-1:0] A_IN   = ADDR_W'(OFF_IN);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DSET = ADDR_W'(OFF_DIRSET);
  localparam logic [ADDR_W-1:0] A_DCLR = ADDR_W'(OFF_DIRCLR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_CFGE = ADDR_W'(OFF_CFG + NPINS);

  logic cfgHit;
  logic [ADDR_W-1:0] cfgOff;

  assign cfgHit = (busAddr >= A_CFG) && (busAddr < A_CFGE);
  assign cfgOff = busAddr - A_CFG;
  assign cfgIdx = cfgOff[IDX_W-1:0];

  always_comb begin
    strobe        = '0;
    strobe.rdSel  = SEL_NONE;
    strobe.cfgWr  = busWrite && cfgHit;
    if (cfgHit) strobe.rdSel = SEL_CFG;
    case (busAddr)
      A_OUT:  begin strobe.outWr   = busWrite; strobe.rdSel = SEL_OUT;  end
      A_OSET: begin strobe.outSet  = busWrite; strobe.rdSel = SEL_OUT;  end
      A_OCLR: begin strobe.outClr  = busWrite; strobe.rdSel = SEL_OUT;  end
      A_IN:   begin                            strobe.rdSel = SEL_IN;   end
      A_DIR:  begin strobe.dirWr   = busWrite; strobe.rdSel = SEL_DIR;  end
      A_DSET: begin strobe.dirSet  = busWrite; strobe.rdSel = SEL_DIR;  end
      A_DCLR: begin strobe.dirClr  = busWrite; strobe.rdSel = SEL_DIR;  end
      A_STAT: begin strobe.statClr = busWrite; strobe.rdSel = SEL_STAT; end
      default: ;
    endcase
  end

  // Only one register may be written in a cycle (R2, R3)
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.outWr, strobe.outSet, strobe.outClr, strobe.dirWr,
              strobe.dirSet, strobe.dirClr, strobe.statClr, strobe.cfgWr}));

endmodule

// File: rtl/gpio_pin_in.sv
module gpio_pin_in
  import gpio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dirBit,
  input  logic       outBit,
  input  logic       discBit,
  input  logic [1:0] pullSel,
  input  logic       extDriven,
  input  logic       extLevel,
  output logic       inBit,
  output logic       clash
);

  logic nextIn;

  always_comb begin
    if (discBit)                nextIn = 1'b0;
    else if (dirBit)            nextIn = outBit;
    else if (extDriven)         nextIn = extLevel;
    else if (pullSel == PULL_UP)   nextIn = 1'b1;
    else if (pullSel == PULL_DOWN) nextIn = 1'b0;
    else                        nextIn = inBit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inBit <= 1'b0;
    else        inBit <= nextIn;
  end

  assign clash = dirBit && extDriven && (extLevel != outBit);

  assert_disc_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    discBit |=> !inBit);

  assert_loopback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!discBit && dirBit) |=> (inBit == $past(outBit)));

  assert_float_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!discBit && !dirBit && !extDriven && !pullSel[0]) |=> $stable(inBit));

endmodule

// File: rtl/gpio_port_dpath.sv
module gpio_port_dpath
  import gpio_port_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NPINS  = 32,
  localparam int IDX_W = $clog2(NPINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strobe,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic              busRead,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NPINS-1:0]  padIn,
  input  logic [NPINS-1:0]  padDriven,
  output logic [NPINS-1:0]  outReg,
  output logic [NPINS-1:0]  dirReg,
  output logic              conflict
);

  logic [NPINS-1:0] wdPins;
  logic [NPINS-1:0] discReg;
  logic [1:0]       pullReg  [NPINS];
  logic [2:0]       drvReg   [NPINS];
  logic [NPINS-1:0] inVec;
  logic [NPINS-1:0] clashVec;
  logic [DATA_W-1:0] cfgWord;

  assign wdPins = busWdata[NPINS-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outReg   <= '0;
      dirReg   <= '0;
      discReg  <= '1;
      conflict <= 1'b0;
      for (int i = 0; i < NPINS; i++) begin
        pullReg[i] <= 2'b00;
        drvReg[i]  <= 3'b000;
      end
    end else begin
      if (strobe.outWr)  outReg <= wdPins;
      if (strobe.outSet) outReg <= outReg | wdPins;
      if (strobe.outClr) outReg <= outReg & ~wdPins;
      if (strobe.dirWr)  dirReg <= wdPins;
      if (strobe.dirSet) dirReg <= dirReg | wdPins;
      if (strobe.dirClr) dirReg <= dirReg & ~wdPins;
      if (strobe.cfgWr) begin
        dirReg[cfgIdx]  <= busWdata[CFG_DIR_BIT];
        discReg[cfgIdx] <= busWdata[CFG_DISC_BIT];
        pullReg[cfgIdx] <= busWdata[CFG_PULL_LO +: 2];
        drvReg[cfgIdx]  <= busWdata[CFG_DRV_LO +: 3];
      end
      if (|clashVec)                          conflict <= 1'b1;
      else if (strobe.statClr && busWdata[0]) conflict <= 1'b0;
    end
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    gpio_pin_in u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .dirBit    (dirReg[p]),
      .outBit    (outReg[p]),
      .discBit   (discReg[p]),
      .pullSel   (pullReg[p]),
      .extDriven (padDriven[p]),
      .extLevel  (padIn[p]),
      .inBit     (inVec[p]),
      .clash     (clashVec[p])
    );
  end

  always_comb begin
    cfgWord = '0;
    cfgWord[CFG_DIR_BIT]      = dirReg[cfgIdx];
    cfgWord[CFG_DISC_BIT]     = discReg[cfgIdx];
    cfgWord[CFG_PULL_LO +: 2] = pullReg[cfgIdx];
    cfgWord[CFG_DRV_LO +: 3]  = drvReg[cfgIdx];
  end

  always_comb begin
    busRdata = '0;
    if (busRead) begin
      case (strobe.rdSel)
        SEL_OUT:  busRdata = DATA_W'(outReg);
        SEL_IN:   busRdata = DATA_W'(inVec);
        SEL_DIR:  busRdata = DATA_W'(dirReg);
        SEL_STAT: busRdata = DATA_W'(conflict);
        SEL_CFG:  busRdata = cfgWord;
        default:  busRdata = '0;
      endcase
    end
  end

  assert_outset_R2: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.outSet |=> (outReg == ($past(outReg) | $past(wdPins))));

  assert_dirclr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.dirClr |=> (dirReg == ($past(dirReg) & ~$past(wdPins))));

  assert_conflict_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict && !(strobe.statClr && busWdata[0])) |=> conflict);

  assert_clash_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|clashVec) |=> conflict);

endmodule

// File: rtl/gpio_pad_port.sv
module gpio_pad_port
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 32,
  parameter int NPINS  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busRead,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [NPINS-1:0]  padIn,
  input  logic [NPINS-1:0]  padDriven,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic              conflict
);

  localparam int IDX_W = $clog2(NPINS);

  strobe_t          strobe;
  logic [IDX_W-1:0] cfgIdx;

  gpio_port_ctrl #(.ADDR_W(ADDR_W), .NPINS(NPINS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .strobe   (strobe),
    .cfgIdx   (cfgIdx)
  );

  gpio_port_dpath #(.DATA_W(DATA_W), .NPINS(NPINS)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .cfgIdx    (cfgIdx),
    .busRead   (busRead),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padDriven (padDriven),
    .outReg    (padOut),
    .dirReg    (padOe),
    .conflict  (conflict)
  );

endmodule

// File: tb/gpio_pad_port_bench.sv
module gpio_pad_port_bench;

  localparam int A_OUT = 0, A_OSET = 1, A_OCLR = 2, A_IN = 3;
  localparam int A_DIR = 4, A_DSET = 5, A_DCLR = 6, A_STAT = 7, A_CFG = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        busRead = 1'b0, busWrite = 1'b0;
  logic [6:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [31:0] padIn = '0, padDriven = '0, padOut, padOe;
  logic        conflict;

  int checks = 0, errors = 0;
  bit done = 0;

  // model state
  logic [31:0] mOut = '0, mDir = '0, mDisc = '1, mIn = '0;
  logic [1:0]  mPull [32];
  logic [2:0]  mDrv  [32];
  logic        mConf = 1'b0;

  gpio_pad_port u_gpio_pad_port (
    .clk(clk), .rst_n(rst_n), .busRead(busRead), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .padIn(padIn), .padDriven(padDriven), .padOut(padOut), .padOe(padOe),
    .conflict(conflict));

  always #10 clk = ~clk;

  function automatic logic [31:0] nextIn();
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      if (mDisc[i])              v[i] = 1'b0;
      else if (mDir[i])          v[i] = mOut[i];
      else if (padDriven[i])     v[i] = padIn[i];
      else if (mPull[i] == 2'b11) v[i] = 1'b1;
      else if (mPull[i] == 2'b01) v[i] = 1'b0;
      else                       v[i] = mIn[i];
    end
    return v;
  endfunction

  function automatic logic [31:0] expRead(int a);
    if (a == A_OUT || a == A_OSET || a == A_OCLR) return mOut;
    if (a == A_IN) return mIn;
    if (a == A_DIR || a == A_DSET || a == A_DCLR) return mDir;
    if (a == A_STAT) return {31'b0, mConf};
    if (a >= A_CFG && a < A_CFG + 32)
      return {21'b0, mDrv[a-A_CFG], 4'b0, mPull[a-A_CFG], mDisc[a-A_CFG], mDir[a-A_CFG]};
    return 32'h0;
  endfunction

  // one clock edge; model advances with pre-edge state
  task automatic step(bit clrReq);
    logic [31:0] nIn;
    logic nConf;
    nIn = nextIn();
    nConf = (|(mDir & padDriven & (padIn ^ mOut))) ? 1'b1 : (clrReq ? 1'b0 : mConf);
    @(posedge clk);
    @(negedge clk);
    mIn = nIn;
    mConf = nConf;
  endtask

  task automatic wr(int a, logic [31:0] d);
    busAddr = 7'(a); busWdata = d; busWrite = 1'b1;
    step(a == A_STAT && d[0]);
    busWrite = 1'b0;
    case (a)
      A_OUT:  mOut = d;
      A_OSET: mOut = mOut | d;
      A_OCLR: mOut = mOut & ~d;
      A_DIR:  mDir = d;
      A_DSET: mDir = mDir | d;
      A_DCLR: mDir = mDir & ~d;
      default: if (a >= A_CFG && a < A_CFG + 32) begin
        mDir[a-A_CFG] = d[0]; mDisc[a-A_CFG] = d[1];
        mPull[a-A_CFG] = d[3:2]; mDrv[a-A_CFG] = d[10:8];
      end
    endcase
  endtask

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdChk(string tag, int a);
    logic [31:0] d;
    busAddr = 7'(a); busRead = 1'b1;
    #1 d = busRdata;
    busRead = 1'b0;
    chk($sformatf("%s addr %0d", tag, a), d, expRead(a));
  endtask

  task automatic rdLit(string tag, int a, logic [31:0] exp);
    logic [31:0] d;
    busAddr = 7'(a); busRead = 1'b1;
    #1 d = busRdata;
    busRead = 1'b0;
    chk($sformatf("%s addr %0d", tag, a), d, exp);
  endtask

  task automatic pads(logic [31:0] drv, logic [31:0] lvl);
    padDriven = drv; padIn = lvl;
    step(1'b0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2718);
    for (int i = 0; i < 32; i++) begin mPull[i] = 2'b00; mDrv[i] = 3'b000; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0);

    // R1 reset state
    for (int a = 0; a < 8; a++) rdLit("R1 reset", a, 32'h0);
    rdLit("R1 reset cfg0", A_CFG, 32'h2);
    rdLit("R1 reset cfg31", A_CFG + 31, 32'h2);
    chk("R1 reset padOe", padOe, 32'h0);
    chk("R1 reset padOut", padOut, 32'h0);

    // R3 / R4 direction aliases and mirror
    wr(A_DSET, 32'h8000_0001);
    rdLit("R3 dirset", A_DIR, 32'h8000_0001);
    rdLit("R4 cfg0 mirror", A_CFG, 32'h3);
    rdLit("R4 cfg31 mirror", A_CFG + 31, 32'h3);
    wr(A_DCLR, 32'h8000_0001);
    rdLit("R3 dirclr", A_DCLR, 32'h0);
    rdLit("R4 cfg31 cleared", A_CFG + 31, 32'h2);
    wr(A_DIR, 32'h8000_0001);
    rdLit("R3 dir write", A_DSET, 32'h8000_0001);
    wr(A_CFG + 31, 32'h2);
    rdLit("R4 cfg write to dir", A_DIR, 32'h0000_0001);
    chk("R10 padOe", padOe, 32'h0000_0001);
    wr(A_DIR, 32'h0);

    // R2 output aliases
    wr(A_OUT, 32'hA5A5_A5A5);
    wr(A_OSET, 32'h0000_000F);
    rdLit("R2 outset", A_OSET, 32'hA5A5_A5AF);
    wr(A_OCLR, 32'hF000_0000);
    rdLit("R2 outclr", A_OCLR, 32'h05A5_A5AF);
    chk("R10 padOut", padOut, 32'h05A5_A5AF);
    wr(A_OUT, 32'h0);

    // R5 / R6 / R7 input path on pin 0
    wr(A_CFG, 32'h0);
    pads(32'h1, 32'h0);
    rdLit("R5 in low", A_IN, 32'h0);
    pads(32'h1, 32'h1);
    rdLit("R5 in high", A_IN, 32'h1);
    pads(32'h0, 32'h0);
    step(1'b0);
    rdLit("R6 hold after release", A_IN, 32'h1);
    wr(A_CFG, 32'h4);
    step(1'b0);
    rdLit("R7 pull-down", A_IN, 32'h0);
    wr(A_CFG, 32'hC);
    step(1'b0);
    rdLit("R7 pull-up", A_IN, 32'h1);
    wr(A_CFG, 32'h0);
    pads(32'h0, 32'h0);
    rdLit("R6 hold after pull removal", A_IN, 32'h1);

    // R8 disconnect
    wr(A_CFG, 32'h2);
    pads(32'h1, 32'h1);
    rdLit("R8 disconnected", A_IN, 32'h0);
    pads(32'h0, 32'h0);

    // R9 / R10 output
    wr(A_CFG, 32'h3);
    wr(A_OSET, 32'h1);
    chk("R10 padOut set", padOut[0], 1'b1);
    chk("R10 padOe set", padOe[0], 1'b1);
    wr(A_CFG, 32'h1);
    step(1'b0);
    rdLit("R9 loopback high", A_IN, 32'h1);
    wr(A_OCLR, 32'h1);
    step(1'b0);
    rdLit("R9 loopback low", A_IN, 32'h0);
    chk("R10 padOut clear", padOut[0], 1'b0);

    // R11 conflict
    wr(A_OSET, 32'h1);
    chk("R11 no conflict", conflict, 1'b0);
    pads(32'h1, 32'h0);
    chk("R11 conflict set", conflict, 1'b1);
    wr(A_STAT, 32'h1);
    chk("R11 clash beats clear", conflict, 1'b1);
    pads(32'h0, 32'h0);
    step(1'b0);
    rdLit("R11 sticky", A_STAT, 32'h1);
    wr(A_STAT, 32'h0);
    chk("R11 zero write keeps", conflict, 1'b1);
    wr(A_STAT, 32'h1);
    chk("R11 cleared", conflict, 1'b0);

    // R12 config field readback
    wr(A_CFG + 5, 32'hFFFF_FFFF);
    rdLit("R12 cfg fields", A_CFG + 5, 32'h0000_070F);
    wr(A_CFG + 5, 32'h2);

    // random phase checked against the model
    for (int it = 0; it < 600; it++) begin
      int kind;
      int a;
      kind = int'($urandom_range(0, 9));
      if (kind < 3) begin
        pads($urandom & $urandom, $urandom);
      end else if (kind < 6) begin
        a = int'($urandom_range(0, 7));
        if (a == A_IN) a = A_OUT;
        wr(a, $urandom);
      end else begin
        wr(A_CFG + int'($urandom_range(0, 31)), $urandom & 32'h0000_070F);
      end
      rdChk("R5 R6 R7 R9 random IN", A_IN);
      a = int'($urandom_range(0, 7));
      rdChk("R2 R3 R11 random reg", a);
      rdChk("R4 R12 random cfg", A_CFG + int'($urandom_range(0, 31)));
      chk("R10 random padOut", padOut, mOut);
      chk("R10 random padOe", padOe, mDir);
      chk("R11 random conflict", {31'b0, conflict}, {31'b0, mConf});
    end

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule